// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 64 interrupt sources and presents them to a processor as two request lines, a normal one and a fast one, together with a 32-bit register window for configuration and inspection. Each source has an enable bit, a routing bit that steers it to either the normal or the fast line, and a software force bit. The enable bits can be changed one at a time by writing a source number to a set-by-number or a clear-by-number word, which spares software a read-modify-write. They can also be written in bulk as two 32-bit words.

Normal requests are further filtered by a 4-bit priority per source and a global mask level. A vector word names the winning normal source, so a handler can dispatch without scanning the pending words. A second vector word names the lowest-numbered fast source. Register writes take effect at the clock edge of the write. Reads, both request lines and both vectors follow the register state and the raw inputs combinationally.

Top module: `vic_top`

## Requirements
- R1: After reset every enable, routing and force bit is 0, the mask level is 0, both request outputs are low and both vector words (0x40, 0x44) read 0xFFFFFFFF.
- R2: A write of value N (0 to 63) to word 0x08 sets enable bit N and leaves every other enable bit as it was. Sources 0 to 31 read back at 0x14 (bit N) and sources 32 to 63 read back at 0x10 (bit N-32).
- R3: A write of value N (0 to 63) to word 0x0C clears enable bit N and leaves every other enable bit as it was.
- R4: A write of any value of 64 or more to 0x08 or 0x0C leaves every enable bit unchanged.
- R5: The enable (0x10 high, 0x14 low), routing (0x18 high, 0x1C low) and force (0x50 high, 0x54 low) words read back what was last written. A high word holds sources 63 to 32 and a low word holds sources 31 to 0.
- R6: Words 0x48 (high) and 0x4C (low) return the current value of src_i in the same cycle.
- R7: A source is active when its input or its force bit is 1. Normal pending (0x58 high, 0x5C low) is active AND enabled AND routing 0. Fast pending (0x60 high, 0x64 low) is active AND enabled AND routing 1.
- R8: fast_irq_o is high exactly when some fast pending bit is set, whatever the priorities and the mask level.
- R9: The priority word for group g (sources 8g to 8g+7) sits at 0x20 + 4*(7-g). Bits 4j+3:4j hold the priority of source 8g+j, and the word reads back as written.
- R10: The mask level is a 5-bit two's-complement value written to bits 4:0 of word 0x04. A normal pending source qualifies when its unsigned priority is greater than the level, so all ones (-1) lets every priority through. norm_irq_o is high exactly when some source qualifies.
- R11: Word 0x40 returns the number of the qualifying source with the highest priority, the lower number winning a tie, or 0xFFFFFFFF when none qualifies.
- R12: Word 0x44 returns the number of the lowest-numbered fast pending source, or 0xFFFFFFFF when there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 7 | Byte address of the register word; accesses with bits 1:0 non-zero are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | 64 | Interrupt source inputs, active high, level |
| norm_irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
A register write takes effect at the rising edge on which the strobe is sampled. Its result can be read through rdata_o, and it reaches both request lines, from the next falling edge on. A change on src_i reaches rdata_o, the vectors and the request lines in the same cycle, with no register between. The bench therefore drives every input at a falling edge. It samples one time unit after the falling edge that follows a write, or one time unit after it changes src_i, and it never samples at a rising edge. The mask-level and priority sweeps recompute the expected vector and request from a model the bench keeps itself.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC    = 64;
  localparam int DW      = 32;
  localparam int AW      = 7;
  localparam int PRIO_W  = 4;
  localparam int MASK_W  = PRIO_W + 1;
  localparam int PER_WRD = DW / PRIO_W;
  localparam int NGRP    = NSRC / PER_WRD;
  localparam int SIDX_W  = $clog2(NSRC);
  localparam int WIDX_W  = AW - 2;

  localparam logic [WIDX_W-1:0] W_CTRL   = 5'd0;
  localparam logic [WIDX_W-1:0] W_MASK   = 5'd1;
  localparam logic [WIDX_W-1:0] W_SETNUM = 5'd2;
  localparam logic [WIDX_W-1:0] W_CLRNUM = 5'd3;
  localparam logic [WIDX_W-1:0] W_ENH    = 5'd4;
  localparam logic [WIDX_W-1:0] W_ENL    = 5'd5;
  localparam logic [WIDX_W-1:0] W_TYPH   = 5'd6;
  localparam logic [WIDX_W-1:0] W_TYPL   = 5'd7;
  localparam logic [WIDX_W-1:0] W_PRIO   = 5'd8;
  localparam logic [WIDX_W-1:0] W_NVEC   = 5'd16;
  localparam logic [WIDX_W-1:0] W_FVEC   = 5'd17;
  localparam logic [WIDX_W-1:0] W_RAWH   = 5'd18;
  localparam logic [WIDX_W-1:0] W_RAWL   = 5'd19;
  localparam logic [WIDX_W-1:0] W_FRCH   = 5'd20;
  localparam logic [WIDX_W-1:0] W_FRCL   = 5'd21;
  localparam logic [WIDX_W-1:0] W_NPH    = 5'd22;
  localparam logic [WIDX_W-1:0] W_NPL    = 5'd23;
  localparam logic [WIDX_W-1:0] W_FPH    = 5'd24;
  localparam logic [WIDX_W-1:0] W_FPL    = 5'd25;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   typ_o,
  output logic [NSRC-1:0]   frc_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [DW-1:0]     prio_wrd_o [NGRP]
);
  localparam int HALF = NSRC / 2;

  logic [NSRC-1:0]   en_q, typ_q, frc_q;
  logic [MASK_W-1:0] mask_q;
  logic [DW-1:0]     prio_q [NGRP];
  logic              num_ok;

  // number writes beyond the source range are dropped
  assign num_ok = (wdata_i[DW-1:SIDX_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      unique case (widx_i)
        W_MASK:   mask_q <= wdata_i[MASK_W-1:0];
        W_SETNUM: if (num_ok) en_q[wdata_i[SIDX_W-1:0]] <= 1'b1;
        W_CLRNUM: if (num_ok) en_q[wdata_i[SIDX_W-1:0]] <= 1'b0;
        W_ENH:    en_q[NSRC-1:HALF]  <= wdata_i;
        W_ENL:    en_q[HALF-1:0]     <= wdata_i;
        W_TYPH:   typ_q[NSRC-1:HALF] <= wdata_i;
        W_TYPL:   typ_q[HALF-1:0]    <= wdata_i;
        W_FRCH:   frc_q[NSRC-1:HALF] <= wdata_i;
        W_FRCL:   frc_q[HALF-1:0]    <= wdata_i;
        default:  ;
      endcase
    end
  end

  // group g lives at word W_PRIO + (NGRP-1-g): highest group at lowest address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NGRP; g++) prio_q[g] <= '0;
    end else if (wr_i) begin
      for (int g = 0; g < NGRP; g++)
        if (widx_i == WIDX_W'(int'(W_PRIO) + NGRP - 1 - g)) prio_q[g] <= wdata_i;
    end
  end

  assign en_o       = en_q;
  assign typ_o      = typ_q;
  assign frc_o      = frc_q;
  assign mask_o     = mask_q;
  assign prio_wrd_o = prio_q;
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]   pend_i,
  input  prio_t             prio_i [NSRC],
  input  logic [MASK_W-1:0] mask_i,
  output logic              any_o,
  output logic [SIDX_W-1:0] idx_o
);
  logic [NSRC-1:0] qual;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign qual[i] = pend_i[i] && ($signed({1'b0, prio_i[i]}) > $signed(mask_i));
  end

  assign any_o = |qual;

  // strict compare keeps the lower index on equal priority
  always_comb begin
    logic  found;
    prio_t best_p;
    found  = 1'b0;
    best_p = '0;
    idx_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!found || prio_i[i] > best_p)) begin
        found  = 1'b1;
        best_p = prio_i[i];
        idx_o  = SIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_first_set.sv
module vic_first_set
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]   vec_i,
  output logic              any_o,
  output logic [SIDX_W-1:0] idx_o
);
  assign any_o = |vec_i;

  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = SIDX_W'(i);
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [6:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [63:0]   src_i,
  output logic          norm_irq_o,
  output logic          fast_irq_o
);
  localparam int HALF = NSRC / 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [NSRC-1:0]   en_bits, typ_bits, frc_bits, act, n_pend, f_pend;
  logic [MASK_W-1:0] mask_lvl;
  logic [DW-1:0]     prio_wrd [NGRP];
  prio_t             prio_f [NSRC];
  logic              n_any, f_any;
  logic [SIDX_W-1:0] n_idx, f_idx;
  logic [DW-1:0]     n_vec, f_vec;

  assign widx    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  vic_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && aligned),
    .widx_i     (widx),
    .wdata_i    (wdata_i),
    .en_o       (en_bits),
    .typ_o      (typ_bits),
    .frc_o      (frc_bits),
    .mask_o     (mask_lvl),
    .prio_wrd_o (prio_wrd)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar j = 0; j < PER_WRD; j++) begin : g_fld
      assign prio_f[g*PER_WRD + j] = prio_wrd[g][j*PRIO_W +: PRIO_W];
    end
  end

  assign act    = src_i | frc_bits;
  assign n_pend = act & en_bits & ~typ_bits;
  assign f_pend = act & en_bits & typ_bits;

  vic_prio_arb u_narb (
    .pend_i (n_pend),
    .prio_i (prio_f),
    .mask_i (mask_lvl),
    .any_o  (n_any),
    .idx_o  (n_idx)
  );

  vic_first_set u_farb (
    .vec_i (f_pend),
    .any_o (f_any),
    .idx_o (f_idx)
  );

  assign n_vec      = n_any ? DW'(n_idx) : '1;
  assign f_vec      = f_any ? DW'(f_idx) : '1;
  assign norm_irq_o = n_any;
  assign fast_irq_o = f_any;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (widx)
        W_MASK:  rdata_o = DW'(mask_lvl);
        W_ENH:   rdata_o = en_bits[NSRC-1:HALF];
        W_ENL:   rdata_o = en_bits[HALF-1:0];
        W_TYPH:  rdata_o = typ_bits[NSRC-1:HALF];
        W_TYPL:  rdata_o = typ_bits[HALF-1:0];
        W_NVEC:  rdata_o = n_vec;
        W_FVEC:  rdata_o = f_vec;
        W_RAWH:  rdata_o = src_i[NSRC-1:HALF];
        W_RAWL:  rdata_o = src_i[HALF-1:0];
        W_FRCH:  rdata_o = frc_bits[NSRC-1:HALF];
        W_FRCL:  rdata_o = frc_bits[HALF-1:0];
        W_NPH:   rdata_o = n_pend[NSRC-1:HALF];
        W_NPL:   rdata_o = n_pend[HALF-1:0];
        W_FPH:   rdata_o = f_pend[NSRC-1:HALF];
        W_FPL:   rdata_o = f_pend[HALF-1:0];
        default: begin
          for (int g = 0; g < NGRP; g++)
            if (widx == WIDX_W'(int'(W_PRIO) + NGRP - 1 - g)) rdata_o = prio_wrd[g];
        end
      endcase
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [6:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [63:0] src_i,
  input logic        norm_irq_o,
  input logic        fast_irq_o,
  input logic [63:0] en_bits,
  input logic [63:0] typ_bits,
  input logic [63:0] frc_bits,
  input logic [4:0]  mask_lvl,
  input logic [31:0] n_vec
);
  logic set_wr, clr_wr;
  assign set_wr = wr_en_i && (addr_i == 7'h08);
  assign clr_wr = wr_en_i && (addr_i == 7'h0C);

  p_setnum_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr && (wdata_i < 32'd64) |=> en_bits[$past(wdata_i[5:0])]);

  p_setnum_others_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr && (wdata_i < 32'd64) |=>
      (en_bits | (64'd1 << $past(wdata_i[5:0]))) == ($past(en_bits) | (64'd1 << $past(wdata_i[5:0]))));

  p_clrnum_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && (wdata_i < 32'd64) |=> !en_bits[$past(wdata_i[5:0])]);

  p_bad_num_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr || clr_wr) && (wdata_i >= 32'd64) |=> $stable(en_bits));

  p_fast_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_irq_o |-> |(en_bits & typ_bits & (src_i | frc_bits)));

  p_unmasked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_lvl == 5'h1F) && |(en_bits & ~typ_bits & (src_i | frc_bits)) |-> norm_irq_o);

  p_vec_none_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !norm_irq_o |-> (n_vec == 32'hFFFF_FFFF));

  p_vec_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_irq_o |-> (n_vec < 32'd64) && en_bits[n_vec[5:0]] && !typ_bits[n_vec[5:0]]);
endmodule

bind vic_top vic_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .src_i      (src_i),
  .norm_irq_o (norm_irq_o),
  .fast_irq_o (fast_irq_o),
  .en_bits    (en_bits),
  .typ_bits   (typ_bits),
  .frc_bits   (frc_bits),
  .mask_lvl   (mask_lvl),
  .n_vec      (n_vec)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic        nirq, firq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] en_m = '0, typ_m = '0, frc_m = '0;
  logic [3:0]  prio_m [64];
  logic [4:0]  mask_m = '0;

  always #4 clk = ~clk;

  vic_top u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .src_i (src),
    .norm_irq_o (nirq), .fast_irq_o (firq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd64(input logic [6:0] hi, input logic [6:0] lo, output logic [63:0] d);
    logic [31:0] h, l;
    rd(hi, h);
    rd(lo, l);
    d = {h, l};
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic wr64(input logic [6:0] hi, input logic [6:0] lo, input logic [63:0] v);
    wr(hi, v[63:32]);
    wr(lo, v[31:0]);
  endtask

  task automatic load_prio();
    for (int g = 0; g < 8; g++) begin
      logic [31:0] w;
      for (int j = 0; j < 8; j++) w[4*j +: 4] = prio_m[8*g + j];
      wr(7'(32'h20 + 4 * (7 - g)), w);
    end
  endtask

  function automatic logic [31:0] exp_nvec();
    int best = -1;
    int lev = mask_m[4] ? int'(mask_m) - 32 : int'(mask_m);
    for (int i = 0; i < 64; i++) begin
      if ((src[i] | frc_m[i]) & en_m[i] & ~typ_m[i] && int'(prio_m[i]) > lev)
        if (best < 0 || prio_m[i] > prio_m[best]) best = i;
    end
    return (best < 0) ? 32'hFFFF_FFFF : 32'(best);
  endfunction

  function automatic logic [31:0] exp_fvec();
    logic [63:0] fp = (src | frc_m) & en_m & typ_m;
    for (int i = 0; i < 64; i++) if (fp[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] d64;
    logic [63:0] pats [4];
    for (int i = 0; i < 64; i++) prio_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd64(7'h10, 7'h14, d64); chk("R1 enable", d64, 64'd0);
    rd64(7'h18, 7'h1C, d64); chk("R1 type", d64, 64'd0);
    rd64(7'h50, 7'h54, d64); chk("R1 force", d64, 64'd0);
    rd(7'h04, d); chk("R1 mask", d, 0);
    rd(7'h40, d); chk("R1 nvec", d, 32'hFFFF_FFFF);
    rd(7'h44, d); chk("R1 fvec", d, 32'hFFFF_FFFF);
    chk("R1 irq outs", {nirq, firq}, 0);

    // R2 set-by-number sweep, walking and accumulating
    for (int n = 0; n < 64; n++) begin
      wr(7'h08, n);
      en_m[n] = 1'b1;
      rd64(7'h10, 7'h14, d64); chk("R2 setnum", d64, en_m);
    end
    // R3 clear-by-number sweep in a scattered order
    for (int k = 0; k < 64; k++) begin
      int n = (k * 37) % 64;
      wr(7'h0C, n);
      en_m[n] = 1'b0;
      rd64(7'h10, 7'h14, d64); chk("R3 clrnum", d64, en_m);
    end

    // R4 out-of-range numbers
    wr64(7'h10, 7'h14, 64'hA5A5_0F0F_3C3C_9696); en_m = 64'hA5A5_0F0F_3C3C_9696;
    wr(7'h08, 64);  wr(7'h08, 32'h0000_0101); wr(7'h0C, 32'hFFFF_FFFF); wr(7'h0C, 65);
    rd64(7'h10, 7'h14, d64); chk("R4 bad number", d64, en_m);

    // R5 bulk readback
    wr64(7'h10, 7'h14, 64'h0123_4567_89AB_CDEF); en_m = 64'h0123_4567_89AB_CDEF;
    rd64(7'h10, 7'h14, d64); chk("R5 enable", d64, en_m);
    wr64(7'h18, 7'h1C, 64'hF0F0_0000_FFFF_0001); typ_m = 64'hF0F0_0000_FFFF_0001;
    rd64(7'h18, 7'h1C, d64); chk("R5 type", d64, typ_m);
    wr64(7'h50, 7'h54, 64'h8000_0001_0000_0010); frc_m = 64'h8000_0001_0000_0010;
    rd64(7'h50, 7'h54, d64); chk("R5 force", d64, frc_m);

    // R6 raw sources, R7 pending words, R8 fast line, R12 fast vector
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h1248_0000_00F0_8421; pats[3] = 64'h0000_8000_0000_0000;
    for (int p = 0; p < 4; p++) begin
      set_src(pats[p]);
      rd64(7'h48, 7'h4C, d64); chk("R6 raw", d64, src);
      rd64(7'h58, 7'h5C, d64); chk("R7 normal pending", d64, (src | frc_m) & en_m & ~typ_m);
      rd64(7'h60, 7'h64, d64); chk("R7 fast pending", d64, (src | frc_m) & en_m & typ_m);
      chk("R8 fast line", firq, |((src | frc_m) & en_m & typ_m));
      rd(7'h44, d); chk("R12 fvec", d, exp_fvec());
    end
    wr64(7'h50, 7'h54, 64'd0); frc_m = '0;
    set_src(64'd0);
    rd(7'h44, d); chk("R12 fvec none", d, 32'hFFFF_FFFF);
    chk("R8 fast idle", firq, 1'b0);

    // R9 priority layout
    for (int i = 0; i < 64; i++) prio_m[i] = 4'((i * 7 + 3) % 16);
    load_prio();
    for (int g = 0; g < 8; g++) begin
      logic [31:0] w;
      for (int j = 0; j < 8; j++) w[4*j +: 4] = prio_m[8*g + j];
      rd(7'(32'h20 + 4 * (7 - g)), d); chk("R9 prio word", d, w);
    end

    // R10/R11 mask-level sweep over every 5-bit value, with ties present
    wr64(7'h10, 7'h14, 64'hFFFF_FFFF_FFFF_FFFF); en_m = '1;
    wr64(7'h18, 7'h1C, 64'h0000_0000_0000_00F0); typ_m = 64'hF0;
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF; pats[1] = 64'h0000_0001_0000_0002;
    pats[2] = 64'h8000_0000_0000_00F0; pats[3] = 64'h0420_0000_0800_0100;
    for (int m = 0; m < 32; m++) begin
      wr(7'h04, m); mask_m = 5'(m);
      rd(7'h04, d); chk("R10 mask readback", d, m);
      for (int p = 0; p < 4; p++) begin
        set_src(pats[p]);
        rd(7'h40, d); chk("R11 nvec", d, exp_nvec());
        chk("R10 normal line", nirq, exp_nvec() != 32'hFFFF_FFFF);
      end
    end

    // R11 tie break: equal priorities, lower number wins
    for (int i = 0; i < 64; i++) prio_m[i] = 4'd5;
    load_prio();
    wr(7'h04, 5'h1F); mask_m = 5'h1F;
    set_src(64'h0010_0000_0000_0200);
    rd(7'h40, d); chk("R11 tie", d, 32'd9);
    set_src(64'd0);
    rd(7'h40, d); chk("R11 none", d, 32'hFFFF_FFFF);
    chk("R10 normal idle", nirq, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule